// File: doc/BRIEF.md
# Fixed-Point Store Formatter

This block sits in the execute stage of a 64-bit load/store pipeline. It takes one decoded store operation per handshake and turns it into the request that the data cache expects. The request holds the effective address, a 64-bit write word with the stored bytes already placed on their lanes, and a byte-enable mask. When the operation updates its base register, the block also returns the value and register number that the register file must write back.

The operation is described by a size code, an addressing form and two flags: update and byte-reverse. It also carries three operand values (base, index, source), the base register number and a 16-bit displacement field. The block checks the combination and raises an invalid flag for forms the architecture forbids. It raises a misalign flag when the access would cross an 8-byte boundary. In either case no byte is enabled and nothing is written back, so the memory side needs no extra logic to drop the request. The block does not split misaligned accesses.

Both sides use valid/ready. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in one output register until the consumer takes it with `out_ready`. The input may push a new operation into that register in the same cycle as the old result leaves. While a result waits with `out_ready` low, `in_ready` is low and every output keeps its value.

Top module: `store_fmt`

## Requirements
- R1: For forms without update, a base register number of 0 makes the base operand zero whatever `base_val` holds; any other number uses `base_val`.
- R2: The effective address is base plus the offset, modulo 2^64. The offset is `disp` sign-extended from 16 bits for form 0 (displacement) and `index_val` for form 2 (indexed).
- R3: Form 1 (shifted displacement) takes `disp[13:0]`, appends two zero bits and sign-extends the 16-bit result. This form is legal only with size 3.
- R4: Size codes 0/1/2/3 store 1/2/4/8 bytes. Without byte reversal, the low bytes of `src_val` are stored, most significant first. The byte for address offset `k = ea[2:0] + i` appears on `out_wdata[(7-k)*8 +: 8]` with `out_be[7-k]` set. All other lanes are zero with their enable clear.
- R5: With byte reversal, the byte stored at `ea + i` is `src_val[8*i +: 8]`, so the least significant source byte comes first.
- R6: An update form uses `base_val` even when the base number is 0. When the store is neither invalid nor misaligned, it raises `out_wb_en` with `out_wb_val` equal to the effective address and `out_wb_num` equal to `base_num`.
- R7: `out_invalid` is raised for any of these: update with base number 0, form 3, form 1 with a size other than 3, or byte reversal with a form other than 2 or with size 0. An invalid store has `out_be` all zero and no write-back.
- R8: `out_misalign` is raised when `ea[2:0]` plus the byte count exceeds 8, whatever the validity. A misaligned store has `out_be` all zero and no write-back.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted operation sets `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_form | input | 2 | 0 displacement, 1 shifted displacement, 2 indexed, 3 reserved |
| op_update | input | 1 | Write address back to base register |
| op_brev | input | 1 | Store bytes in reversed order |
| base_num | input | 5 | Base register number |
| base_val | input | 64 | Base register contents |
| index_val | input | 64 | Index register contents |
| src_val | input | 64 | Source register contents |
| disp | input | 16 | Displacement field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_ea | output | 64 | Effective address |
| out_wdata | output | 64 | Lane-placed write data |
| out_be | output | 8 | Byte enables, bit j covers out_wdata[8j+7:8j] |
| out_wb_en | output | 1 | Base register write-back request |
| out_wb_num | output | 5 | Write-back register number |
| out_wb_val | output | 64 | Write-back value |
| out_invalid | output | 1 | Forbidden form |
| out_misalign | output | 1 | Access crosses an 8-byte boundary |

## Verification
On every cycle the assertions check several relations. A flagged store carries no enables and no write-back. A legal store enables exactly 1, 2, 4 or 8 lanes. Every write-back carries the effective address and a non-zero register number. A stalled result holds steady, and an accepted operation always appears on the next edge. The exact address arithmetic, the base-zero and shifted-displacement rules, the byte order in both directions and the lane placement can be seen only through the bench's vectors, whose expected values are worked out from the requirements.

// File: rtl/store_fmt_pkg.sv
package store_fmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } st_size_e;

  typedef enum logic [1:0] {
    FM_DISP    = 2'd0,
    FM_DISP_SH = 2'd1,
    FM_INDEX   = 2'd2,
    FM_RSVD    = 2'd3
  } st_form_e;

endpackage

// File: rtl/store_ea_gen.sv
module store_ea_gen
  import store_fmt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int DISP_W   = 16,
  parameter int SHDISP_W = 14,
  parameter int REG_AW   = 5
) (
  input  logic [1:0]        form,
  input  logic              update,
  input  logic [REG_AW-1:0] base_num,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);
  localparam int SH_PAD = DISP_W - SHDISP_W;

  logic [XLEN-1:0]   base_eff;
  logic [DISP_W-1:0] sh_raw;
  logic [XLEN-1:0]   d_ext;
  logic [XLEN-1:0]   sh_ext;
  logic [XLEN-1:0]   offs;

  // register zero reads as literal zero only when no write-back happens (R1, R6)
  assign base_eff = (!update && (base_num == '0)) ? '0 : base_val;

  assign sh_raw = {disp[SHDISP_W-1:0], {SH_PAD{1'b0}}};
  assign d_ext  = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
  assign sh_ext = {{(XLEN-DISP_W){sh_raw[DISP_W-1]}}, sh_raw};

  always_comb begin
    unique case (form)
      FM_INDEX:   offs = index_val;
      FM_DISP_SH: offs = sh_ext;
      default:    offs = d_ext;
    endcase
  end

  assign ea = base_eff + offs;
endmodule

// File: rtl/store_form_check.sv
module store_form_check
  import store_fmt_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int LANE_AW = 3
) (
  input  logic [1:0]         size,
  input  logic [1:0]         form,
  input  logic               update,
  input  logic               brev,
  input  logic [REG_AW-1:0]  base_num,
  input  logic [LANE_AW-1:0] ea_low,
  output logic               invalid,
  output logic               misalign
);
  localparam int LANES = 1 << LANE_AW;
  localparam logic [LANE_AW:0] LANES_W = (LANE_AW+1)'(LANES);

  logic [LANE_AW:0] nbytes;
  logic [LANE_AW:0] end_pos;
  logic             bad_update;
  logic             bad_form;
  logic             bad_brev;

  assign nbytes  = {{LANE_AW{1'b0}}, 1'b1} << size;
  assign end_pos = {1'b0, ea_low} + nbytes;

  assign bad_update = update && (base_num == '0);
  assign bad_form   = (form == FM_RSVD) || ((form == FM_DISP_SH) && (size != SZ_DWORD));
  assign bad_brev   = brev && ((form != FM_INDEX) || (size == SZ_BYTE));

  assign invalid  = bad_update || bad_form || bad_brev;
  assign misalign = end_pos > LANES_W;
endmodule

// File: rtl/store_lane_pack.sv
module store_lane_pack #(
  parameter int XLEN = 64
) (
  input  logic [1:0]                 size,
  input  logic                       brev,
  input  logic                       enable,
  input  logic [$clog2(XLEN/8)-1:0]  ea_low,
  input  logic [XLEN-1:0]            src,
  output logic [XLEN-1:0]            wdata,
  output logic [XLEN/8-1:0]          be
);
  localparam int LANES   = XLEN / 8;
  localparam int LANE_AW = $clog2(LANES);
  localparam logic [LANE_AW-1:0] LAST = LANE_AW'(LANES - 1);

  logic [7:0]       src_b [LANES];
  logic [LANE_AW:0] nbytes;

  assign nbytes = {{LANE_AW{1'b0}}, 1'b1} << size;

  for (genvar m = 0; m < LANES; m++) begin : g_src
    assign src_b[m] = src[m*8 +: 8];
  end

  // lane j carries the byte at address offset LANES-1-j (big-endian lanes)
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [LANE_AW-1:0] OFFS = LANE_AW'(LANES - 1 - j);
    logic [LANE_AW-1:0] rel;
    logic [LANE_AW-1:0] pick;
    logic [LANE_AW-1:0] m_sel;
    logic               hit;

    always_comb begin
      rel   = OFFS - ea_low;
      hit   = enable && (OFFS >= ea_low) && ({1'b0, rel} < nbytes);
      // pick: big-endian byte number inside the source register
      pick  = brev ? (LAST - rel) : (rel - nbytes[LANE_AW-1:0]);
      m_sel = LAST - pick;
    end

    assign wdata[j*8 +: 8] = hit ? src_b[m_sel] : 8'h00;
    assign be[j]           = hit;
  end
endmodule

// File: rtl/store_fmt.sv
module store_fmt
  import store_fmt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int DISP_W   = 16,
  parameter int SHDISP_W = 14,
  parameter int REG_AW   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          op_size,
  input  logic [1:0]          op_form,
  input  logic                op_update,
  input  logic                op_brev,
  input  logic [REG_AW-1:0]   base_num,
  input  logic [XLEN-1:0]     base_val,
  input  logic [XLEN-1:0]     index_val,
  input  logic [XLEN-1:0]     src_val,
  input  logic [DISP_W-1:0]   disp,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [XLEN-1:0]     out_ea,
  output logic [XLEN-1:0]     out_wdata,
  output logic [XLEN/8-1:0]   out_be,
  output logic                out_wb_en,
  output logic [REG_AW-1:0]   out_wb_num,
  output logic [XLEN-1:0]     out_wb_val,
  output logic                out_invalid,
  output logic                out_misalign
);
  localparam int LANES   = XLEN / 8;
  localparam int LANE_AW = $clog2(LANES);

  logic [XLEN-1:0]  ea_c;
  logic             inv_c;
  logic             mis_c;
  logic             ok_c;
  logic [XLEN-1:0]  wdata_c;
  logic [LANES-1:0] be_c;
  logic             accept;

  store_ea_gen #(
    .XLEN(XLEN), .DISP_W(DISP_W), .SHDISP_W(SHDISP_W), .REG_AW(REG_AW)
  ) u_ea (
    .form(op_form), .update(op_update), .base_num(base_num),
    .base_val(base_val), .index_val(index_val), .disp(disp), .ea(ea_c)
  );

  store_form_check #(
    .REG_AW(REG_AW), .LANE_AW(LANE_AW)
  ) u_chkform (
    .size(op_size), .form(op_form), .update(op_update), .brev(op_brev),
    .base_num(base_num), .ea_low(ea_c[LANE_AW-1:0]),
    .invalid(inv_c), .misalign(mis_c)
  );

  assign ok_c = !inv_c && !mis_c;

  store_lane_pack #(
    .XLEN(XLEN)
  ) u_pack (
    .size(op_size), .brev(op_brev), .enable(ok_c),
    .ea_low(ea_c[LANE_AW-1:0]), .src(src_val),
    .wdata(wdata_c), .be(be_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ea       <= '0;
      out_wdata    <= '0;
      out_be       <= '0;
      out_wb_en    <= 1'b0;
      out_wb_num   <= '0;
      out_wb_val   <= '0;
      out_invalid  <= 1'b0;
      out_misalign <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_ea       <= ea_c;
        out_wdata    <= wdata_c;
        out_be       <= be_c;
        out_wb_en    <= op_update && ok_c;
        out_wb_num   <= base_num;
        out_wb_val   <= ea_c;
        out_invalid  <= inv_c;
        out_misalign <= mis_c;
      end
    end
  end
endmodule

// File: rtl/store_fmt_chk.sv
module store_fmt_chk #(
  parameter int XLEN   = 64,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_ea,
  input logic [XLEN-1:0]   out_wdata,
  input logic [XLEN/8-1:0] out_be,
  input logic              out_wb_en,
  input logic [REG_AW-1:0] out_wb_num,
  input logic [XLEN-1:0]   out_wb_val,
  input logic              out_invalid,
  input logic              out_misalign
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_wdata)
      && $stable(out_be) && $stable(out_wb_en) && $stable(out_invalid)
      && $stable(out_misalign))); // R9

  AST_FLAGGED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_invalid || out_misalign)) |-> (out_be == '0 && !out_wb_en)); // R7

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_misalign) |-> (out_be == '0)); // R8

  AST_LEGAL_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && !out_misalign) |->
      ($countones(out_be) == 1 || $countones(out_be) == 2 ||
       $countones(out_be) == 4 || $countones(out_be) == 8)); // R4

  AST_WB_CARRIES_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_en) |-> (out_wb_val == out_ea && out_wb_num != '0)); // R6

  AST_DISABLED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_be == '0) |-> (out_wdata == '0)); // R4
endmodule

bind store_fmt store_fmt_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_fmt_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
  .out_wdata(out_wdata), .out_be(out_be), .out_wb_en(out_wb_en),
  .out_wb_num(out_wb_num), .out_wb_val(out_wb_val),
  .out_invalid(out_invalid), .out_misalign(out_misalign)
);

// File: tb/store_fmt_tb.sv
module store_fmt_tb;
  localparam logic [63:0] SRC = 64'h0102030405060708;

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  fm;
    logic        upd;
    logic        brv;
    logic [4:0]  bn;
    logic [63:0] base;
    logic [63:0] idx;
    logic [15:0] dsp;
    logic [63:0] ea;
    logic        inv;
    logic        mis;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 5'd3,  64'h1000, 64'h0,  16'h0005, 64'h1005, 1'b0, 1'b0}, // R2 R4 byte
    '{2'd0, 2'd0, 1'b0, 1'b0, 5'd0,  64'h1000, 64'h0,  16'h0005, 64'h0005, 1'b0, 1'b0}, // R1 base zero
    '{2'd1, 2'd2, 1'b0, 1'b0, 5'd4,  64'h2000, 64'h6,  16'h0000, 64'h2006, 1'b0, 1'b0}, // R2 R4 half
    '{2'd1, 2'd2, 1'b0, 1'b1, 5'd4,  64'h2000, 64'h6,  16'h0000, 64'h2006, 1'b0, 1'b0}, // R5 half
    '{2'd2, 2'd0, 1'b0, 1'b0, 5'd5,  64'h3008, 64'h0,  16'hFFFC, 64'h3004, 1'b0, 1'b0}, // R2 negative
    '{2'd2, 2'd2, 1'b0, 1'b1, 5'd6,  64'h4000, 64'h4,  16'h0000, 64'h4004, 1'b0, 1'b0}, // R5 word
    '{2'd3, 2'd1, 1'b0, 1'b0, 5'd8,  64'h5000, 64'h0,  16'h0002, 64'h5008, 1'b0, 1'b0}, // R3
    '{2'd3, 2'd1, 1'b0, 1'b0, 5'd8,  64'h5010, 64'h0,  16'h3FFF, 64'h500C, 1'b0, 1'b1}, // R3 R8
    '{2'd3, 2'd2, 1'b0, 1'b1, 5'd10, 64'h6000, 64'h10, 16'h0000, 64'h6010, 1'b0, 1'b0}, // R5 dword
    '{2'd2, 2'd0, 1'b1, 1'b0, 5'd7,  64'h7000, 64'h0,  16'h0010, 64'h7010, 1'b0, 1'b0}, // R6
    '{2'd2, 2'd0, 1'b1, 1'b0, 5'd0,  64'h8000, 64'h0,  16'h0020, 64'h8020, 1'b1, 1'b0}, // R6 R7
    '{2'd2, 2'd0, 1'b0, 1'b1, 5'd2,  64'h1000, 64'h0,  16'h0000, 64'h1000, 1'b1, 1'b0}, // R7 brev disp
    '{2'd0, 2'd2, 1'b0, 1'b1, 5'd2,  64'h1000, 64'h1,  16'h0000, 64'h1001, 1'b1, 1'b0}, // R7 brev byte
    '{2'd1, 2'd2, 1'b0, 1'b0, 5'd1,  64'h9007, 64'h0,  16'h0000, 64'h9007, 1'b0, 1'b1}, // R8
    '{2'd2, 2'd1, 1'b0, 1'b0, 5'd1,  64'h0100, 64'h0,  16'h0001, 64'h0104, 1'b1, 1'b0}, // R3 R7 size
    '{2'd3, 2'd2, 1'b1, 1'b0, 5'd9,  64'hA000, 64'h18, 16'h0000, 64'hA018, 1'b0, 1'b0}, // R6 indexed
    '{2'd0, 2'd0, 1'b0, 1'b0, 5'd1,  64'h10000, 64'h0, 16'h8000, 64'h8000, 1'b0, 1'b0}, // R2 sign bit
    '{2'd1, 2'd3, 1'b0, 1'b0, 5'd1,  64'h0010, 64'h0,  16'h0000, 64'h0010, 1'b1, 1'b0}, // R7 form 3
    '{2'd2, 2'd2, 1'b1, 1'b0, 5'd12, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8, 16'h0000, 64'h4, 1'b0, 1'b0} // R2 wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op_size = '0;
  logic [1:0]  op_form = '0;
  logic        op_update = 1'b0;
  logic        op_brev = 1'b0;
  logic [4:0]  base_num = '0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [63:0] src_val = '0;
  logic [15:0] disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_ea;
  logic [63:0] out_wdata;
  logic [7:0]  out_be;
  logic        out_wb_en;
  logic [4:0]  out_wb_num;
  logic [63:0] out_wb_val;
  logic        out_invalid;
  logic        out_misalign;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  store_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_size(op_size), .op_form(op_form), .op_update(op_update), .op_brev(op_brev),
    .base_num(base_num), .base_val(base_val), .index_val(index_val),
    .src_val(src_val), .disp(disp), .out_valid(out_valid), .out_ready(out_ready),
    .out_ea(out_ea), .out_wdata(out_wdata), .out_be(out_be), .out_wb_en(out_wb_en),
    .out_wb_num(out_wb_num), .out_wb_val(out_wb_val), .out_invalid(out_invalid),
    .out_misalign(out_misalign)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected lanes from R4 (normal order) and R5 (reversed order)
  task automatic ref_pack(input logic [1:0] sz, input logic brv, input logic [2:0] off,
                          input logic ok, output logic [63:0] wd, output logic [7:0] be);
    int n;
    n  = 1 << sz;
    wd = '0;
    be = '0;
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        int b;
        int k;
        b = brv ? (7 - i) : (8 - n + i);
        k = int'(off) + i;
        wd[(7-k)*8 +: 8] = SRC[(7-b)*8 +: 8];
        be[7-k] = 1'b1;
      end
    end
  endtask

  task automatic drive(input vec_t v);
    op_size   = v.sz;
    op_form   = v.fm;
    op_update = v.upd;
    op_brev   = v.brv;
    base_num  = v.bn;
    base_val  = v.base;
    index_val = v.idx;
    disp      = v.dsp;
    src_val   = SRC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ewd;
    logic [7:0]  ebe;
    logic        ok;
    logic        ewb;

    repeat (3) @(negedge clk);
    check("R10", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R10", "in_ready after reset", 64'(in_ready), 64'd1);

    for (int t = 0; t < NV; t++) begin
      @(negedge clk);
      drive(VECS[t]);
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      ok  = !VECS[t].inv && !VECS[t].mis;
      ewb = VECS[t].upd && ok;
      ref_pack(VECS[t].sz, VECS[t].brv, VECS[t].ea[2:0], ok, ewd, ebe);
      check("R9", $sformatf("vec%0d out_valid", t), 64'(out_valid), 64'd1);
      check("R2", $sformatf("vec%0d ea", t), out_ea, VECS[t].ea);
      check("R4", $sformatf("vec%0d wdata", t), out_wdata, ewd);
      check("R4", $sformatf("vec%0d be", t), 64'(out_be), 64'(ebe));
      check("R7", $sformatf("vec%0d invalid", t), 64'(out_invalid), 64'(VECS[t].inv));
      check("R8", $sformatf("vec%0d misalign", t), 64'(out_misalign), 64'(VECS[t].mis));
      check("R6", $sformatf("vec%0d wb_en", t), 64'(out_wb_en), 64'(ewb));
      if (ewb) begin
        check("R6", $sformatf("vec%0d wb_val", t), out_wb_val, VECS[t].ea);
        check("R6", $sformatf("vec%0d wb_num", t), 64'(out_wb_num), 64'(VECS[t].bn));
      end
    end

    // explicit byte-order spot checks
    // R5: reversed word at offset 4 -> lanes 3..0 hold 08 07 06 05
    // R4: halfword at offset 6 -> lanes 1..0 hold 07 08
    @(negedge clk);
    drive(VECS[5]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", "reversed word lanes", out_wdata, 64'h0000_0000_0807_0605);
    @(negedge clk);
    drive(VECS[2]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4", "normal half lanes", out_wdata, 64'h0000_0000_0000_0708);

    // back-pressure: R9
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", "valid under stall", 64'(out_valid), 64'd1);
    check("R9", "ready low under stall", 64'(in_ready), 64'd0);
    drive(VECS[4]);
    repeat (3) @(negedge clk);
    check("R9", "ea held under stall", out_ea, VECS[0].ea);
    check("R9", "be held under stall", 64'(out_be), 64'h04);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "next op after release", out_ea, VECS[4].ea);
    check("R9", "valid after release", 64'(out_valid), 64'd1);
    @(posedge clk);
    @(negedge clk);
    check("R9", "drained", 64'(out_valid), 64'd0);

    // reset in the middle of a result: R10
    drive(VECS[9]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "valid cleared by reset", 64'(out_valid), 64'd0);
    check("R10", "ready after reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule